// File: doc/BRIEF.md
# Strobed Port Interrupt Status Controller

This block holds the interrupt state of a two-port I/O expander. Each port has a strobe pin. When a port is set up as an input and its strobe makes the chosen transition, the block captures the port's input bus into a holding register and marks that port pending. A separate one-cycle pulse reports that a nonvolatile programming cycle has finished. That pulse sets its own completion flag.

A host reaches the block over a simple register bus. The bus gives access to one 8-bit status/enable register and to the two captured data registers. Each source has its own enable bit. The enabled pending conditions are ORed into one interrupt output, and the top bit of the status register shows the same value. The host services a port either by reading that port's captured data or by writing 0 to its pending bit. The completion flag is cleared only by writing 0 to it.

Top module: `strobe_port_irq_ctrl`

## Requirements
- R1: After reset the status register reads 0x00, both captured data registers read 0x00 and `irq` is 0.
- R2: The status register (address 0) holds, from bit 7 down to bit 0: interrupt, port A pending, port B pending, port A enable, port B enable, completion enable, a constant 0, completion flag. Bit 1 always reads 0. Writes to bits 7 and 1 have no effect.
- R3: The three enable bits (4, 3, 2) read back the value last written to them.
- R4: A port whose direction input is 1 (input) sets its pending bit on the strobe edge selected by its polarity input (1 = rising, 0 = falling). At that edge it captures its data bus. The opposite edge neither sets the bit nor recaptures the data.
- R5: While a port's direction input is 0 (output), its strobe changes neither its pending bit nor its captured data.
- R6: Reading address 1 clears port A pending, and reading address 2 clears port B pending. The captured value stays readable afterwards.
- R7: Writing 0 to bit 6 or bit 5 of the status register clears that pending bit. Writing 1 leaves the bit unchanged and never sets it.
- R8: A `prog_done` pulse sets the completion flag. Only a status write with bit 0 = 0 clears it, and a pulse in the same cycle as that write leaves the flag set. Writing 1 to the flag and reading the data registers do not change it.
- R9: `irq` and status bit 7 both equal (A pending AND A enable) OR (B pending AND B enable) OR (completion flag AND completion enable). A pending bit whose enable is 0 stays visible without raising `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | ADDR_W | Register address: 0 status, 1 port A data, 2 port B data |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_rd | input | 1 | Read strobe (clears a pending bit on data reads) |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for the addressed register |
| strb_a | input | 1 | Port A strobe pin (asynchronous) |
| strb_b | input | 1 | Port B strobe pin (asynchronous) |
| pa_din | input | DATA_W | Port A input data bus |
| pb_din | input | DATA_W | Port B input data bus |
| pa_is_input | input | 1 | Port A direction, 1 = input |
| pb_is_input | input | 1 | Port B direction, 1 = input |
| pa_rise_edge | input | 1 | Port A strobe polarity, 1 = rising, 0 = falling |
| pb_rise_edge | input | 1 | Port B strobe polarity, 1 = rising, 0 = falling |
| prog_done | input | 1 | One-cycle pulse at the end of a programming cycle |
| irq | output | 1 | Interrupt request to the host |

## Verification
On each strobe pulse the bench changes the data bus between the active and the inactive edge. A detector that fires on both edges, or a capture taken on the wrong edge, therefore reads back the complemented byte. A status write that keeps the pending bits at 1 must leave them set, which exposes a design that treats pending bits as plain read/write storage. The bench raises `prog_done` in the same cycle as a clearing write. A design that gives the clear priority loses the completion. Masked pending bits, a port configured as an output, falling-edge mode and a reset in the middle of the run are each checked, because each of them either blocks or depends on the path from strobe to `irq`.

// File: rtl/strb_irq_pkg.sv
package strb_irq_pkg;
  // register addresses
  localparam int unsigned ADDR_STATUS = 0;
  localparam int unsigned ADDR_LAT_A  = 1;
  localparam int unsigned ADDR_LAT_B  = 2;
  // status register bit positions (host software decodes these)
  localparam int unsigned BIT_INT  = 7;
  localparam int unsigned BIT_PA   = 6;
  localparam int unsigned BIT_PB   = 5;
  localparam int unsigned BIT_ENA  = 4;
  localparam int unsigned BIT_ENB  = 3;
  localparam int unsigned BIT_ENEE = 2;
  localparam int unsigned BIT_EOW  = 0;
  localparam int unsigned STATUS_W = 8;
  localparam int unsigned NUM_PORTS = 2;
endpackage

// File: rtl/strb_rst_sync.sv
module strb_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_ns = sh_q[STAGES-1];
endmodule

// File: rtl/strb_edge_detect.sv
module strb_edge_detect #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic rise_sel,
  output logic evt
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [SYNC_STAGES-1:0] sync_d;
  logic                   prev_q;
  logic                   prev_d;
  logic                   cur;

  assign cur = sync_q[SYNC_STAGES-1];

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], pin};
    prev_d = cur;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  always_comb begin
    if (rise_sel) evt = cur & ~prev_q;
    else          evt = ~cur & prev_q;
  end
endmodule

// File: rtl/strb_port_capture.sv
module strb_port_capture #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt,
  input  logic              is_input,
  input  logic [DATA_W-1:0] din,
  input  logic              rd_clr,
  input  logic              wr_clr,
  output logic              pending,
  output logic [DATA_W-1:0] held
);
  logic              pend_q, pend_d;
  logic [DATA_W-1:0] held_q, held_d;
  logic              cap_en;

  assign cap_en = evt & is_input;

  always_comb begin
    pend_d = pend_q;
    if (rd_clr | wr_clr) pend_d = 1'b0;
    if (cap_en)          pend_d = 1'b1;
    held_d = cap_en ? din : held_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      held_q <= '0;
    end else begin
      pend_q <= pend_d;
      held_q <= held_d;
    end
  end

  assign pending = pend_q;
  assign held    = held_q;
endmodule

// File: rtl/strb_status_core.sv
module strb_status_core (
  input  logic clk,
  input  logic rst_n,
  input  logic status_wr,
  input  logic wr_ena,
  input  logic wr_enb,
  input  logic wr_enee,
  input  logic wr_eow,
  input  logic prog_done,
  input  logic pend_a,
  input  logic pend_b,
  output logic ena,
  output logic enb,
  output logic enee,
  output logic eow,
  output logic irq
);
  logic [2:0] en_q, en_d;
  logic       eow_q, eow_d;

  always_comb begin
    en_d  = status_wr ? {wr_ena, wr_enb, wr_enee} : en_q;
    eow_d = eow_q;
    if (status_wr && !wr_eow) eow_d = 1'b0;
    if (prog_done)            eow_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      eow_q <= 1'b0;
    end else begin
      en_q  <= en_d;
      eow_q <= eow_d;
    end
  end

  assign ena  = en_q[2];
  assign enb  = en_q[1];
  assign enee = en_q[0];
  assign eow  = eow_q;
  assign irq  = (pend_a & en_q[2]) | (pend_b & en_q[1]) | (eow_q & en_q[0]);
endmodule

// File: rtl/strobe_port_irq_ctrl.sv
module strobe_port_irq_ctrl
  import strb_irq_pkg::*;
#(
  parameter int unsigned ADDR_W      = 2,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RST_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              strb_a,
  input  logic              strb_b,
  input  logic [DATA_W-1:0] pa_din,
  input  logic [DATA_W-1:0] pb_din,
  input  logic              pa_is_input,
  input  logic              pb_is_input,
  input  logic              pa_rise_edge,
  input  logic              pb_rise_edge,
  input  logic              prog_done,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(ADDR_STATUS);
  localparam logic [ADDR_W-1:0] A_LAT_A  = ADDR_W'(ADDR_LAT_A);
  localparam logic [ADDR_W-1:0] A_LAT_B  = ADDR_W'(ADDR_LAT_B);

  logic rst_ns;

  logic [NUM_PORTS-1:0] pin_v, rise_v, dir_v, evt_v, pend_v, rdclr_v, wrclr_v;
  logic [DATA_W-1:0]    din_v  [NUM_PORTS];
  logic [DATA_W-1:0]    held_v [NUM_PORTS];

  logic status_wr;
  logic ena, enb, enee, eow;
  logic [STATUS_W-1:0] status;

  // signals observed by the bound checker
  logic evt_a, evt_b, flag_a, flag_b;

  strb_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ns (rst_ns)
  );

  assign pin_v    = {strb_b, strb_a};
  assign rise_v   = {pb_rise_edge, pa_rise_edge};
  assign dir_v    = {pb_is_input, pa_is_input};
  assign din_v[0] = pa_din;
  assign din_v[1] = pb_din;

  assign status_wr  = bus_wr && (bus_addr == A_STATUS);
  assign rdclr_v[0] = bus_rd && (bus_addr == A_LAT_A);
  assign rdclr_v[1] = bus_rd && (bus_addr == A_LAT_B);
  assign wrclr_v[0] = status_wr && !bus_wdata[BIT_PA];
  assign wrclr_v[1] = status_wr && !bus_wdata[BIT_PB];

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    strb_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk      (clk),
      .rst_n    (rst_ns),
      .pin      (pin_v[p]),
      .rise_sel (rise_v[p]),
      .evt      (evt_v[p])
    );
    strb_port_capture #(.DATA_W(DATA_W)) u_cap (
      .clk      (clk),
      .rst_n    (rst_ns),
      .evt      (evt_v[p]),
      .is_input (dir_v[p]),
      .din      (din_v[p]),
      .rd_clr   (rdclr_v[p]),
      .wr_clr   (wrclr_v[p]),
      .pending  (pend_v[p]),
      .held     (held_v[p])
    );
  end

  strb_status_core u_core (
    .clk       (clk),
    .rst_n     (rst_ns),
    .status_wr (status_wr),
    .wr_ena    (bus_wdata[BIT_ENA]),
    .wr_enb    (bus_wdata[BIT_ENB]),
    .wr_enee   (bus_wdata[BIT_ENEE]),
    .wr_eow    (bus_wdata[BIT_EOW]),
    .prog_done (prog_done),
    .pend_a    (pend_v[0]),
    .pend_b    (pend_v[1]),
    .ena       (ena),
    .enb       (enb),
    .enee      (enee),
    .eow       (eow),
    .irq       (irq)
  );

  always_comb begin
    status           = '0;
    status[BIT_INT]  = irq;
    status[BIT_PA]   = pend_v[0];
    status[BIT_PB]   = pend_v[1];
    status[BIT_ENA]  = ena;
    status[BIT_ENB]  = enb;
    status[BIT_ENEE] = enee;
    status[BIT_EOW]  = eow;
  end

  always_comb begin
    case (bus_addr)
      A_STATUS: bus_rdata = DATA_W'(status);
      A_LAT_A:  bus_rdata = held_v[0];
      A_LAT_B:  bus_rdata = held_v[1];
      default:  bus_rdata = '0;
    endcase
  end

  assign evt_a  = evt_v[0];
  assign evt_b  = evt_v[1];
  assign flag_a = pend_v[0];
  assign flag_b = pend_v[1];

  logic unused_wbits;
  assign unused_wbits = ^bus_wdata;
endmodule

// File: rtl/strobe_port_irq_chk.sv
module strobe_port_irq_chk
  import strb_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              pa_is_input,
  input logic              pb_is_input,
  input logic              prog_done,
  input logic              irq,
  input logic              evt_a,
  input logic              evt_b,
  input logic              flag_a,
  input logic              flag_b,
  input logic              eow
);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(ADDR_STATUS);
  localparam logic [ADDR_W-1:0] A_LAT_A  = ADDR_W'(ADDR_LAT_A);
  localparam logic [ADDR_W-1:0] A_LAT_B  = ADDR_W'(ADDR_LAT_B);

  AST_BIT1_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == A_STATUS) |-> (bus_rdata[1] == 1'b0)); // R2
  AST_INT_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == A_STATUS) |-> (bus_rdata[BIT_INT] == irq)); // R9
  AST_PA_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_a) |-> $past(evt_a && pa_is_input)); // R4
  AST_PB_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_b) |-> $past(evt_b && pb_is_input)); // R5
  AST_PA_RDCLR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == A_LAT_A && !evt_a) |=> !flag_a); // R6
  AST_PB_RDCLR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == A_LAT_B && !evt_b) |=> !flag_b); // R6
  AST_PA_NOWRSET: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_a && !evt_a) |=> !flag_a); // R7
  AST_EOW_SET: assert property (@(posedge clk) disable iff (!rst_n)
    prog_done |=> eow); // R8
  AST_EOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (eow && !(bus_wr && bus_addr == A_STATUS && !bus_wdata[BIT_EOW])) |=> eow); // R8
endmodule

bind strobe_port_irq_ctrl strobe_port_irq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_ns),
  .bus_addr    (bus_addr),
  .bus_wr      (bus_wr),
  .bus_rd      (bus_rd),
  .bus_wdata   (bus_wdata),
  .bus_rdata   (bus_rdata),
  .pa_is_input (pa_is_input),
  .pb_is_input (pb_is_input),
  .prog_done   (prog_done),
  .irq         (irq),
  .evt_a       (evt_a),
  .evt_b       (evt_b),
  .flag_a      (flag_a),
  .flag_b      (flag_b),
  .eow         (eow)
);

// File: tb/tb_strobe_port_irq_ctrl.sv
`timescale 1ns/1ps
module tb_strobe_port_irq_ctrl;
  localparam int ADDR_W = 2;
  localparam int DATA_W = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic              bus_wr = 1'b0;
  logic              bus_rd = 1'b0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic [DATA_W-1:0] bus_rdata;
  logic              strb_a = 1'b0;
  logic              strb_b = 1'b0;
  logic [DATA_W-1:0] pa_din = '0;
  logic [DATA_W-1:0] pb_din = '0;
  logic              pa_is_input = 1'b1;
  logic              pb_is_input = 1'b1;
  logic              pa_rise_edge = 1'b1;
  logic              pb_rise_edge = 1'b1;
  logic              prog_done = 1'b0;
  logic              irq;

  int n_checks = 0;
  int n_fail   = 0;

  always #2 clk = ~clk;

  strobe_port_irq_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .strb_a(strb_a), .strb_b(strb_b),
    .pa_din(pa_din), .pb_din(pb_din), .pa_is_input(pa_is_input), .pb_is_input(pb_is_input),
    .pa_rise_edge(pa_rise_edge), .pb_rise_edge(pb_rise_edge), .prog_done(prog_done), .irq(irq)
  );

  // ops: 0 write status, 1 read status, 2 read A, 3 read B, 4 strobe A, 5 strobe B, 6 done pulse
  // entry = {op, arg, expected read, expected irq}
  localparam int NV = 29;
  localparam logic [19:0] VEC [NV] = '{
    {3'd1, 8'h00, 8'h00, 1'b0},  // 0  R1 reset state
    {3'd0, 8'h1C, 8'h00, 1'b0},  // 1  enable all
    {3'd1, 8'h00, 8'h1C, 1'b0},  // 2  R3 enables read back
    {3'd4, 8'h5A, 8'h00, 1'b0},  // 3  strobe A
    {3'd1, 8'h00, 8'hDC, 1'b1},  // 4  R4 A pending, irq
    {3'd2, 8'h00, 8'h5A, 1'b0},  // 5  R4 captured data
    {3'd1, 8'h00, 8'h1C, 1'b0},  // 6  R6 read cleared A
    {3'd5, 8'hC3, 8'h00, 1'b0},  // 7  strobe B
    {3'd1, 8'h00, 8'hBC, 1'b1},  // 8  R4 B pending
    {3'd0, 8'h3C, 8'h00, 1'b0},  // 9  write 1 to B pending
    {3'd1, 8'h00, 8'hBC, 1'b1},  // 10 R7 write 1 no effect
    {3'd0, 8'h1C, 8'h00, 1'b0},  // 11 write 0 to B pending
    {3'd1, 8'h00, 8'h1C, 1'b0},  // 12 R7 cleared
    {3'd3, 8'h00, 8'hC3, 1'b0},  // 13 R6 data kept after clear
    {3'd6, 8'h00, 8'h00, 1'b0},  // 14 completion pulse
    {3'd1, 8'h00, 8'h9D, 1'b1},  // 15 R8 flag set
    {3'd2, 8'h00, 8'h5A, 1'b0},  // 16 read A data
    {3'd1, 8'h00, 8'h9D, 1'b1},  // 17 R8 data read does not clear
    {3'd0, 8'h1D, 8'h00, 1'b0},  // 18 write 1 to flag
    {3'd1, 8'h00, 8'h9D, 1'b1},  // 19 R8 still set
    {3'd0, 8'h1C, 8'h00, 1'b0},  // 20 write 0 to flag
    {3'd1, 8'h00, 8'h1C, 1'b0},  // 21 R8 cleared
    {3'd0, 8'h00, 8'h00, 1'b0},  // 22 disable all
    {3'd4, 8'h11, 8'h00, 1'b0},  // 23 strobe A masked
    {3'd1, 8'h00, 8'h40, 1'b0},  // 24 R9 masked pending, no irq
    {3'd0, 8'hD2, 8'h00, 1'b0},  // 25 keep A, ENA, bits 7 and 1 set
    {3'd1, 8'h00, 8'hD0, 1'b1},  // 26 R2 bits 7/1 ignored
    {3'd0, 8'h00, 8'h00, 1'b0},  // 27 clear everything
    {3'd1, 8'h00, 8'h00, 1'b0}   // 28 R7 all clear
  };

  function automatic string step_req(int i);
    case (i)
      0: return "R1";
      2: return "R3";
      4, 5, 8: return "R4";
      6, 13: return "R6";
      10, 12, 28: return "R7";
      15, 17, 19, 21: return "R8";
      24: return "R9";
      26: return "R2";
      default: return "R9";
    endcase
  endfunction

  task automatic check(string req, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  task automatic wr_status(logic [7:0] v);
    @(negedge clk);
    bus_addr = 2'd0; bus_wdata = v; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_reg(logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] v, output logic iv);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1;
    v = bus_rdata; iv = irq;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  // pulse a strobe: active edge with data d, then the data changes before the inactive edge
  task automatic strobe(bit port_b, logic [7:0] d);
    @(negedge clk);
    if (!port_b) begin pa_din = d; strb_a = pa_rise_edge; end
    else         begin pb_din = d; strb_b = pb_rise_edge; end
    repeat (4) @(negedge clk);
    if (!port_b) begin pa_din = ~d; strb_a = ~pa_rise_edge; end
    else         begin pb_din = ~d; strb_b = ~pb_rise_edge; end
    repeat (4) @(negedge clk);
  endtask

  task automatic done_pulse();
    @(negedge clk);
    prog_done = 1'b1;
    @(negedge clk);
    prog_done = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    logic       iv;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 data registers clear after reset
    rd_reg(2'd1, v, iv); check("R1", v, 8'h00);
    rd_reg(2'd2, v, iv); check("R1", v, 8'h00);

    for (int i = 0; i < NV; i++) begin
      logic [2:0] op;
      logic [7:0] arg, ex;
      logic       exi;
      {op, arg, ex, exi} = VEC[i];
      case (op)
        3'd0: wr_status(arg);
        3'd1: begin
          rd_reg(2'd0, v, iv);
          check(step_req(i), v, ex);
          check({step_req(i), " irq"}, {7'd0, iv}, {7'd0, exi});
        end
        3'd2: begin rd_reg(2'd1, v, iv); check(step_req(i), v, ex); end
        3'd3: begin rd_reg(2'd2, v, iv); check(step_req(i), v, ex); end
        3'd4: strobe(1'b0, arg);
        3'd5: strobe(1'b1, arg);
        default: done_pulse();
      endcase
    end

    // R5 port A as output: strobe ignored
    pa_is_input = 1'b0;
    wr_status(8'h1C);
    strobe(1'b0, 8'hEE);
    rd_reg(2'd0, v, iv); check("R5", v, 8'h1C);
    check("R5 irq", {7'd0, iv}, 8'h00);
    rd_reg(2'd1, v, iv); check("R5", v, 8'h11);
    pa_is_input = 1'b1;

    // R4 falling-edge mode on port B
    pb_rise_edge = 1'b0;
    @(negedge clk); strb_b = 1'b1;
    repeat (5) @(negedge clk);
    rd_reg(2'd0, v, iv); check("R4", v, 8'h1C);
    strobe(1'b1, 8'h77);
    rd_reg(2'd0, v, iv); check("R4", v, 8'hBC);
    rd_reg(2'd2, v, iv); check("R4", v, 8'h77);
    rd_reg(2'd0, v, iv); check("R6", v, 8'h1C);

    // R8 completion pulse coinciding with a clearing write
    done_pulse();
    @(negedge clk);
    bus_addr = 2'd0; bus_wdata = 8'h1C; bus_wr = 1'b1; prog_done = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; prog_done = 1'b0;
    rd_reg(2'd0, v, iv); check("R8", v, 8'h9D);
    check("R9 irq", {7'd0, iv}, 8'h01);

    // R1 reset in the middle of the run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 irq", {7'd0, irq}, 8'h00);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    rd_reg(2'd0, v, iv); check("R1", v, 8'h00);
    rd_reg(2'd1, v, iv); check("R1", v, 8'h00);
    rd_reg(2'd2, v, iv); check("R1", v, 8'h00);

    finish_run();
  end
endmodule